// File: doc/BRIEF.md
# JTAG Register Bus Bridge

This block is a JTAG test access port that drives a small on-chip register bus. A standard sixteen-state TAP controller steps on TCK and TMS. A 4-bit instruction register picks which data register sits between TDI and TDO. One instruction code selects a 66-bit command register. The command register holds an enable flag, a read/write flag, a 32-bit byte address and 32-bit data. When an Update-DR finishes with the enable flag set, the block issues exactly one bus access to its local register file.

A write needs one scan. A read needs two. The first scan posts the request, the bus read happens at its Update-DR, and the result is held. The next Capture-DR loads that result into the command register, so the second scan shifts it out.

A group of four instruction codes routes data scans to external per-sub-block command registers. For these codes the block drives select and strobe lines and takes a serial return bit from each sub-block. The local register file holds:
- a control word with a module enable and a self-clearing soft reset;
- five general 32-bit words;
- a word whose bits drive output pins;
- a word that is copied to a parallel port when it is read;
- a word with one read-only status bit.

Top module: `jtag_regbridge`

## Requirements
- R1: TAP reset. The TAP enters Test-Logic-Reset when `trst_n` is low, or after five rising TCK edges with TMS high. In that state the instruction becomes BYPASS (0xF). Capture-IR loads 0b0001, which shifts out LSB first as the bits 1,0,0,0.
- R2: Instruction 0x8 selects the 66-bit command register. Any code that is neither 0x8 nor 0x4..0x7 selects a 1-bit bypass register. The bypass register captures 0 and delays TDI by one TCK.
- R3: Command register fields: bit 65 = enable, bit 64 = read (1) or write (0), bits 63:32 = byte address, bits 31:0 = data. It shifts LSB first. A scan with enable=1 and read=0 writes the data at the end of its Update-DR. A scan with enable=0 makes no bus access.
- R4: A scan with enable=1 and read=1 performs the bus read at its Update-DR. The next Capture-DR loads bits 65:64 = 0, bits 63:32 = the address that was read, and bits 31:0 = the read value.
- R5: The mapped words are the word-aligned byte offsets 0x00 through 0x20. A read of any other address (unaligned, or above 0x20) returns 0. A write to any other address changes nothing.
- R6: Offset 0x00, bit 0 is the module enable and drives `mod_en`. Writing 1 to bit 1 clears every other register-file word. Bit 1 always reads 0.
- R7: Offset 0x14: bit 0 drives `pin_a`, bit 1 drives `pin_b`, bits 5:2 drive `grp_c`, and bits 9:6 drive `grp_d`. Bits above 9 read 0.
- R8: Offset 0x1C: bit 0 reads the live `supply_good` input, and writes to it are ignored. Bits 3:1 are read/write. Higher bits read 0.
- R9: A bus read of offset 0x18 copies that word to `par_out`. `par_valid` is high for exactly one TCK, in the cycle after the read's Update-DR. Otherwise `par_out` holds its value.
- R10: Instruction 0x4|n (n = 0..3) raises `sb_sel[n]` only, and during Shift-DR TDO carries `sb_tdo[n]`. `sb_capture`, `sb_shift` and `sb_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while a sub-block is selected.
- R11: TDO changes only on falling TCK edges. `tdo_en` is high only in Shift-IR and Shift-DR. TDO is 0 whenever `tdo_en` is low.
- R12: When `rst_n` is low, every register-file word, `par_out` and `par_valid` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; also clocks the register file |
| trst_n | input | 1 | Active-low asynchronous TAP reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| rst_n | input | 1 | Active-low asynchronous register-file reset |
| supply_good | input | 1 | Status bit read at offset 0x1C bit 0 |
| mod_en | output | 1 | Module enable, offset 0x00 bit 0 |
| pin_a | output | 1 | Offset 0x14 bit 0 |
| pin_b | output | 1 | Offset 0x14 bit 1 |
| grp_c | output | 4 | Offset 0x14 bits 5:2 |
| grp_d | output | 4 | Offset 0x14 bits 9:6 |
| par_out | output | 32 | Copy of offset 0x18, taken when it is read |
| par_valid | output | 1 | One-cycle pulse when `par_out` is loaded |
| sb_sel | output | 4 | One-hot sub-block select |
| sb_tdi | output | 1 | Serial data to the sub-blocks |
| sb_capture | output | 1 | Capture-DR strobe to the selected sub-block |
| sb_shift | output | 1 | Shift-DR strobe to the selected sub-block |
| sb_update | output | 1 | Update-DR strobe to the selected sub-block |
| sb_tdo | input | 4 | Serial return bit from each sub-block |

## Verification
The assertions assume that TMS and TDI are stable around each rising TCK edge. They also assume the two resets are applied as whole pulses, and that `supply_good` does not change during a scan. The bench meets these assumptions:
- It changes inputs only at falling edges.
- It holds each reset low across at least one full TCK period.
- It changes `supply_good` only while the TAP idles.

The five-high TMS rule is checked with a counter in the checker rather than a long `$past`. The bench enters Test-Logic-Reset both from an active instruction and through the asynchronous pin.

// File: rtl/jtb_pkg.sv
package jtb_pkg;

   typedef enum logic [3:0] {
      TAP_RESET,  TAP_IDLE,
      DR_SELECT,  DR_CAPTURE, DR_SHIFT, DR_EXIT1, DR_PAUSE, DR_EXIT2, DR_UPDATE,
      IR_SELECT,  IR_CAPTURE, IR_SHIFT, IR_EXIT1, IR_PAUSE, IR_EXIT2, IR_UPDATE
   } tap_st_e;

   // one-step transition of the test access port controller
   function automatic tap_st_e tap_next(tap_st_e s, logic tms);
      tap_st_e n;
      case (s)
         TAP_RESET:  n = tms ? TAP_RESET : TAP_IDLE;
         TAP_IDLE:   n = tms ? DR_SELECT : TAP_IDLE;
         DR_SELECT:  n = tms ? IR_SELECT : DR_CAPTURE;
         DR_CAPTURE: n = tms ? DR_EXIT1  : DR_SHIFT;
         DR_SHIFT:   n = tms ? DR_EXIT1  : DR_SHIFT;
         DR_EXIT1:   n = tms ? DR_UPDATE : DR_PAUSE;
         DR_PAUSE:   n = tms ? DR_EXIT2  : DR_PAUSE;
         DR_EXIT2:   n = tms ? DR_UPDATE : DR_SHIFT;
         DR_UPDATE:  n = tms ? DR_SELECT : TAP_IDLE;
         IR_SELECT:  n = tms ? TAP_RESET : IR_CAPTURE;
         IR_CAPTURE: n = tms ? IR_EXIT1  : IR_SHIFT;
         IR_SHIFT:   n = tms ? IR_EXIT1  : IR_SHIFT;
         IR_EXIT1:   n = tms ? IR_UPDATE : IR_PAUSE;
         IR_PAUSE:   n = tms ? IR_EXIT2  : IR_PAUSE;
         IR_EXIT2:   n = tms ? IR_UPDATE : IR_SHIFT;
         default:    n = tms ? DR_SELECT : TAP_IDLE;
      endcase
      return n;
   endfunction

   // register-file slot of each general-purpose word
   localparam int NUM_GP = 5;
   function automatic logic [3:0] gp_slot(int k);
      case (k)
         0:       return 4'd1;
         1:       return 4'd2;
         2:       return 4'd3;
         3:       return 4'd4;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/jtb_tap_ctrl.sv
module jtb_tap_ctrl
   import jtb_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_e st
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= TAP_RESET;
      else         st <= tap_next(st, tms);
   end

endmodule

// File: rtl/jtb_instr.sv
module jtb_instr
   import jtb_pkg::*;
#(
   parameter int          IR_W        = 4,
   parameter logic [IR_W-1:0] BYPASS_CODE = '1
) (
   input  logic            tck,
   input  logic            trst_n,
   input  tap_st_e         st,
   input  logic            tdi,
   output logic [IR_W-1:0] ir,
   output logic            sr_lsb
);

   logic [IR_W-1:0] sr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr <= '0;
         ir <= BYPASS_CODE;
      end else begin
         case (st)
            TAP_RESET:  ir <= BYPASS_CODE;
            IR_CAPTURE: sr <= IR_W'(2'b01);
            IR_SHIFT:   sr <= {tdi, sr[IR_W-1:1]};
            IR_UPDATE:  ir <= sr;
            default:    ;
         endcase
      end
   end

   assign sr_lsb = sr[0];

endmodule

// File: rtl/jtb_cmd_dr.sv
module jtb_cmd_dr
   import jtb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              sel,
   input  tap_st_e           st,
   input  logic              tdi,
   input  logic [DATA_W-1:0] rdata,
   output logic              sr_lsb,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata
);

   localparam int CMD_W  = ADDR_W + DATA_W + 2;
   localparam int EN_BIT = CMD_W - 1;
   localparam int RD_BIT = CMD_W - 2;

   logic [CMD_W-1:0]  sr;
   logic [DATA_W-1:0] rd_hold;
   logic [ADDR_W-1:0] addr_hold;

   assign bus_req   = sel && (st == DR_UPDATE) && sr[EN_BIT];
   assign bus_we    = !sr[RD_BIT];
   assign bus_addr  = sr[CMD_W-3:DATA_W];
   assign bus_wdata = sr[DATA_W-1:0];
   assign sr_lsb    = sr[0];

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr        <= '0;
         rd_hold   <= '0;
         addr_hold <= '0;
      end else begin
         if (sel && st == DR_CAPTURE)    sr <= {2'b00, addr_hold, rd_hold};
         else if (sel && st == DR_SHIFT) sr <= {tdi, sr[CMD_W-1:1]};
         if (bus_req && !bus_we) begin
            rd_hold   <= rdata;
            addr_hold <= bus_addr;
         end
      end
   end

endmodule

// File: rtl/jtb_regs.sv
module jtb_regs
   import jtb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int GRP_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              supply_good,
   output logic [DATA_W-1:0] rdata,
   output logic              mod_en,
   output logic              pin_a,
   output logic              pin_b,
   output logic [GRP_W-1:0]  grp_c,
   output logic [GRP_W-1:0]  grp_d,
   output logic [DATA_W-1:0] par_out,
   output logic              par_valid
);

   localparam int PIN_BITS = 2 + 2 * GRP_W;
   localparam logic [3:0] LAST_SLOT = 4'd8;

   logic [3:0] idx;
   logic       hit, wr, rd, soft_clr;

   assign idx      = addr[5:2];
   assign hit      = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:6] == '0) && (idx <= LAST_SLOT);
   assign wr       = req && we && hit;
   assign rd       = req && !we && hit;
   assign soft_clr = wr && (idx == 4'd0) && wdata[1];

   logic                en_q;
   logic [PIN_BITS-1:0] pins_q;
   logic [DATA_W-1:0]   par_q;
   logic [2:0]          ana_q;
   logic [DATA_W-1:0]   gp_rd [NUM_GP];

   for (genvar k = 0; k < NUM_GP; k++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      q <= '0;
         else if (soft_clr)               q <= '0;
         else if (wr && idx == gp_slot(k)) q <= wdata;
      end
      assign gp_rd[k] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         pins_q    <= '0;
         par_q     <= '0;
         ana_q     <= '0;
         par_out   <= '0;
         par_valid <= 1'b0;
      end else begin
         par_valid <= rd && (idx == 4'd6);
         if (rd && idx == 4'd6) par_out <= par_q;
         if (soft_clr) begin
            en_q   <= wdata[0];
            pins_q <= '0;
            par_q  <= '0;
            ana_q  <= '0;
         end else if (wr) begin
            case (idx)
               4'd0:    en_q   <= wdata[0];
               4'd5:    pins_q <= wdata[PIN_BITS-1:0];
               4'd6:    par_q  <= wdata;
               4'd7:    ana_q  <= wdata[3:1];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         case (idx)
            4'd0:    rdata[0] = en_q;
            4'd5:    rdata[PIN_BITS-1:0] = pins_q;
            4'd6:    rdata = par_q;
            4'd7:    rdata[3:0] = {ana_q, supply_good};
            default: begin
               for (int k = 0; k < NUM_GP; k++)
                  if (idx == gp_slot(k)) rdata = gp_rd[k];
            end
         endcase
      end
   end

   assign mod_en = en_q;
   assign pin_a  = pins_q[0];
   assign pin_b  = pins_q[1];
   assign grp_c  = pins_q[2 +: GRP_W];
   assign grp_d  = pins_q[2 + GRP_W +: GRP_W];

endmodule

// File: rtl/jtag_regbridge.sv
module jtag_regbridge
   import jtb_pkg::*;
#(
   parameter int IR_W     = 4,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int GRP_W    = 4,
   parameter int NUM_SUB  = 4,
   parameter logic [IR_W-1:0] CMD_CODE    = IR_W'(8),
   parameter logic [IR_W-1:0] SUB_BASE    = IR_W'(4),
   parameter logic [IR_W-1:0] BYPASS_CODE = '1
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   output logic               tdo_en,
   input  logic               rst_n,
   input  logic               supply_good,
   output logic               mod_en,
   output logic               pin_a,
   output logic               pin_b,
   output logic [GRP_W-1:0]   grp_c,
   output logic [GRP_W-1:0]   grp_d,
   output logic [DATA_W-1:0]  par_out,
   output logic               par_valid,
   output logic [NUM_SUB-1:0] sb_sel,
   output logic               sb_tdi,
   output logic               sb_capture,
   output logic               sb_shift,
   output logic               sb_update,
   input  logic [NUM_SUB-1:0] sb_tdo
);

   if (IR_W < 4)                    begin : g_bad_ir   $error("IR_W must be at least 4"); end
   if (NUM_SUB < 1 || NUM_SUB > 4)  begin : g_bad_sub  $error("NUM_SUB must be 1..4"); end
   if (ADDR_W < 7)                  begin : g_bad_addr $error("ADDR_W must cover offset 0x20"); end
   if (DATA_W < 2 + 2 * GRP_W)      begin : g_bad_data $error("DATA_W too narrow for pin word"); end

   tap_st_e             tap_st;
   logic [IR_W-1:0]     ir;
   logic                ir_bit, cmd_bit, cmd_sel, byp_sel, byp_q, tdo_nx;
   logic                bus_req, bus_we;
   logic [ADDR_W-1:0]   bus_addr;
   logic [DATA_W-1:0]   bus_wdata, bus_rdata;

   jtb_tap_ctrl u_tap (.tck(tck), .trst_n(trst_n), .tms(tms), .st(tap_st));

   jtb_instr #(.IR_W(IR_W), .BYPASS_CODE(BYPASS_CODE)) u_ir (
      .tck(tck), .trst_n(trst_n), .st(tap_st), .tdi(tdi), .ir(ir), .sr_lsb(ir_bit));

   assign cmd_sel = (ir == CMD_CODE);

   for (genvar n = 0; n < NUM_SUB; n++) begin : g_sub
      assign sb_sel[n] = (ir == (SUB_BASE | IR_W'(n)));
   end

   assign byp_sel    = !cmd_sel && (sb_sel == '0);
   assign sb_tdi     = tdi;
   assign sb_capture = (sb_sel != '0) && (tap_st == DR_CAPTURE);
   assign sb_shift   = (sb_sel != '0) && (tap_st == DR_SHIFT);
   assign sb_update  = (sb_sel != '0) && (tap_st == DR_UPDATE);

   jtb_cmd_dr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
      .tck(tck), .trst_n(trst_n), .sel(cmd_sel), .st(tap_st), .tdi(tdi),
      .rdata(bus_rdata), .sr_lsb(cmd_bit), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata));

   jtb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRP_W(GRP_W)) u_regs (
      .clk(tck), .rst_n(rst_n), .req(bus_req), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .supply_good(supply_good), .rdata(bus_rdata),
      .mod_en(mod_en), .pin_a(pin_a), .pin_b(pin_b), .grp_c(grp_c), .grp_d(grp_d),
      .par_out(par_out), .par_valid(par_valid));

   // one-bit bypass path
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                               byp_q <= 1'b0;
      else if (byp_sel && tap_st == DR_CAPTURE)  byp_q <= 1'b0;
      else if (byp_sel && tap_st == DR_SHIFT)    byp_q <= tdi;
   end

   always_comb begin
      case (tap_st)
         IR_SHIFT: tdo_nx = ir_bit;
         DR_SHIFT: begin
            if (cmd_sel)            tdo_nx = cmd_bit;
            else if (sb_sel != '0)  tdo_nx = |(sb_sel & sb_tdo);
            else                    tdo_nx = byp_q;
         end
         default:  tdo_nx = 1'b0;
      endcase
   end

   // serial output launched on the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo    <= tdo_nx;
         tdo_en <= (tap_st == IR_SHIFT) || (tap_st == DR_SHIFT);
      end
   end

endmodule

// File: rtl/jtb_checker.sv
module jtb_checker
   import jtb_pkg::*;
#(
   parameter int NUM_SUB = 4,
   parameter int DATA_W  = 32
) (
   input logic               tck,
   input logic               trst_n,
   input logic               rst_n,
   input logic               tms,
   input tap_st_e            tap_st,
   input logic               tdo,
   input logic               tdo_en,
   input logic [NUM_SUB-1:0] sb_sel,
   input logic [DATA_W-1:0]  par_out,
   input logic               par_valid,
   input logic               mod_en
);

   logic [2:0] high_cnt;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)               high_cnt <= '0;
      else if (!tms)             high_cnt <= '0;
      else if (high_cnt != 3'd7) high_cnt <= high_cnt + 3'd1;
   end

   a_r1_five_high_reset: assert property (@(posedge tck) disable iff (!trst_n)
      (high_cnt >= 3'd5) |-> (tap_st == TAP_RESET));

   a_r11_quiet_tdo: assert property (@(posedge tck) disable iff (!trst_n)
      !tdo_en |-> !tdo);

   a_r11_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (tap_st == DR_SHIFT || tap_st == IR_SHIFT));

   a_r10_sel_onehot: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0(sb_sel));

   a_r9_valid_pulse: assert property (@(posedge tck) disable iff (!rst_n)
      par_valid |=> !par_valid);

   a_r9_par_hold: assert property (@(posedge tck) disable iff (!rst_n)
      !par_valid |-> $stable(par_out));

   a_r6_enable_on_update: assert property (@(posedge tck) disable iff (!rst_n || !trst_n)
      !$stable(mod_en) |-> ($past(tap_st) == DR_UPDATE));

endmodule

bind jtag_regbridge jtb_checker #(.NUM_SUB(NUM_SUB), .DATA_W(DATA_W)) u_chk (
   .tck(tck), .trst_n(trst_n), .rst_n(rst_n), .tms(tms), .tap_st(tap_st),
   .tdo(tdo), .tdo_en(tdo_en), .sb_sel(sb_sel), .par_out(par_out),
   .par_valid(par_valid), .mod_en(mod_en));

// File: tb/tb_jtag_regbridge.sv
`timescale 1ns/1ps
module tb_jtag_regbridge;

   logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b0, tdi = 1'b0;
   logic        rst_n = 1'b0, supply_good = 1'b0;
   logic [3:0]  sb_tdo = 4'b1010;
   logic        tdo, tdo_en, mod_en, pin_a, pin_b, par_valid;
   logic [3:0]  grp_c, grp_d, sb_sel;
   logic [31:0] par_out;
   logic        sb_tdi, sb_capture, sb_shift, sb_update;

   always #10 tck = ~tck;   // 50 MHz

   jtag_regbridge dut (.*);

   int n_chk = 0, n_fail = 0;
   bit mon_on = 1'b0;
   int en_bad = 0;
   bit last_en;

   // behavioural reference: register file as a word array
   logic [31:0] m [9];
   logic [31:0] exp_par = '0;

   task automatic chk(string req, string what, logic [65:0] got, logic [65:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   function automatic bit mapped(logic [31:0] a);
      return (a[1:0] == 2'b00) && (a <= 32'h20);
   endfunction

   function automatic logic [31:0] model_read(logic [31:0] a);
      if (!mapped(a)) return '0;
      if (a[5:2] == 4'd7) return {28'd0, m[7][3:1], supply_good};
      return m[a[5:2]];
   endfunction

   task automatic model_write(logic [31:0] a, logic [31:0] d);
      if (!mapped(a)) return;
      case (a[5:2])
         4'd0: begin
            m[0] = {31'd0, d[0]};
            if (d[1]) for (int i = 1; i < 9; i++) m[i] = '0;
         end
         4'd5:    m[5] = {22'd0, d[9:0]};
         4'd7:    m[7] = {28'd0, d[3:1], 1'b0};
         default: m[a[5:2]] = d;
      endcase
   endtask

   task automatic model_clear();
      for (int i = 0; i < 9; i++) m[i] = '0;
      exp_par = '0;
   endtask

   // pins compared against the model on every clock
   always @(negedge tck) begin
      if (mon_on) begin
         #3;
         chk("R6", "mod_en", 66'(mod_en), 66'(m[0][0]));
         chk("R7", "pins", 66'({grp_d, grp_c, pin_b, pin_a}), 66'(m[5][9:0]));
         chk("R9", "par_out", 66'(par_out), 66'(exp_par));
      end
   end

   task automatic step(input logic t, input logic d, output logic o);
      @(negedge tck);
      tms = t;
      tdi = d;
      #5;
      o = tdo;
      last_en = tdo_en;
      @(posedge tck);
      #1;
   endtask

   task automatic scan_ir(input logic [3:0] code, output logic [3:0] q);
      logic o;
      step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < 4; i++) begin
         step(i == 3, code[i], q[i]);
         if (!last_en) en_bad++;
      end
      step(1, 0, o); step(0, 0, o);
   endtask

   task automatic scan_dr(input logic [65:0] din, input int n, output logic [65:0] q);
      logic o;
      q = '0;
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], q[i]);
         if (!last_en) en_bad++;
      end
      step(1, 0, o); step(0, 0, o);
   endtask

   task automatic bus_write(logic [31:0] a, logic [31:0] d);
      logic [65:0] q;
      scan_dr({2'b10, a, d}, 66, q);
      model_write(a, d);
   endtask

   task automatic bus_read(string req, logic [31:0] a);
      logic [65:0] q;
      logic [31:0] v;
      logic o;
      v = model_read(a);
      scan_dr({2'b11, a, 32'h0}, 66, q);
      if (mapped(a) && a[5:2] == 4'd6) exp_par = v;
      chk("R9", "par_valid after read", 66'(par_valid), 66'(mapped(a) && a[5:2] == 4'd6));
      step(0, 0, o);
      chk("R9", "par_valid one cycle", 66'(par_valid), 66'(0));
      scan_dr(66'd0, 66, q);
      chk(req, $sformatf("read %h", a), q, {2'b00, a, v});
   endtask

   task automatic bypass_scan(string req);
      logic [65:0] q, d;
      d = 66'h2D;
      scan_dr(d, 8, q);
      chk(req, "bypass", q[7:0], {d[6:0], 1'b0});
   endtask

   initial begin
      logic [3:0] iq;
      logic o;
      model_clear();
      #45;
      rst_n = 1'b1;
      trst_n = 1'b1;
      step(0, 0, o);
      // R12 / R11 reset state
      chk("R11", "tdo idle", 66'({tdo, tdo_en}), 66'(0));
      chk("R12", "par_out reset", 66'({par_out, par_valid}), 66'(0));
      mon_on = 1'b1;

      // R1 IR capture pattern, R2 bypass after reset
      bypass_scan("R1");
      scan_ir(4'h8, iq);
      chk("R1", "IR capture", 66'(iq), 66'(4'b0001));

      // R3 / R4 write and read back
      bus_write(32'h04, 32'hA5A5_1234);
      bus_write(32'h20, 32'h0BAD_F00D);
      bus_read("R4", 32'h04);
      bus_read("R4", 32'h20);
      bus_read("R3", 32'h08);

      // R3 enable clear: no access
      begin
         logic [65:0] q;
         scan_dr({2'b00, 32'h04, 32'hFFFF_0000}, 66, q);
      end
      bus_read("R3", 32'h04);

      // R7 pin word
      bus_write(32'h14, 32'hFFFF_FFFF);
      chk("R7", "all pins high", 66'({grp_d, grp_c, pin_b, pin_a}), 66'(10'h3FF));
      bus_read("R7", 32'h14);
      bus_write(32'h14, 32'h0000_0159);
      chk("R7", "pin_a", 66'(pin_a), 66'(1));
      chk("R7", "grp_c", 66'(grp_c), 66'(4'h6));
      chk("R7", "grp_d", 66'(grp_d), 66'(4'h5));

      // R8 read-only status bit
      bus_write(32'h1C, 32'hFFFF_FFFF);
      bus_read("R8", 32'h1C);
      supply_good = 1'b1;
      bus_read("R8", 32'h1C);
      bus_write(32'h1C, 32'h0);
      bus_read("R8", 32'h1C);

      // R5 unmapped accesses
      bus_write(32'h24, 32'h1111_1111);
      bus_write(32'h06, 32'h2222_2222);
      bus_write(32'h1000_0004, 32'h3333_3333);
      bus_read("R5", 32'h24);
      bus_read("R5", 32'h06);
      bus_read("R5", 32'h04);

      // R9 parallel copy
      bus_write(32'h18, 32'hCAFE_0018);
      bus_read("R9", 32'h18);
      bus_write(32'h18, 32'h1234_5678);
      bus_read("R9", 32'h10);

      // R6 enable and soft reset
      bus_write(32'h00, 32'h1);
      chk("R6", "mod_en set", 66'(mod_en), 66'(1));
      bus_write(32'h00, 32'h3);
      bus_read("R6", 32'h00);
      bus_read("R6", 32'h04);
      bus_read("R6", 32'h14);

      // R10 sub-block routing
      begin
         logic [65:0] q;
         scan_ir(4'h5, iq);
         chk("R10", "sb_sel n=1", 66'(sb_sel), 66'(4'b0010));
         scan_dr(66'h0, 6, q);
         chk("R10", "sub tdo n=1", q[5:0], 66'(6'h3F));
         scan_ir(4'h4, iq);
         chk("R10", "sb_sel n=0", 66'(sb_sel), 66'(4'b0001));
         scan_dr(66'h3F, 6, q);
         chk("R10", "sub tdo n=0", q[5:0], 66'(6'h00));
         chk("R10", "strobes idle", 66'({sb_capture, sb_shift, sb_update}), 66'(0));
      end

      // R2 undecoded code
      scan_ir(4'h3, iq);
      chk("R2", "no sub select", 66'(sb_sel), 66'(0));
      bypass_scan("R2");

      // R1 five TMS-high clocks
      scan_ir(4'h8, iq);
      for (int i = 0; i < 5; i++) step(1, 0, o);
      step(0, 0, o);
      bypass_scan("R1");

      // R1 asynchronous TAP reset
      scan_ir(4'h8, iq);
      @(negedge tck); trst_n = 1'b0;
      @(negedge tck); trst_n = 1'b1;
      step(0, 0, o);
      bypass_scan("R1");

      chk("R11", "tdo_en during shifts", 66'(en_bad), 66'(0));

      // R12 system reset clears the file
      scan_ir(4'h8, iq);
      bus_write(32'h0C, 32'h5555_AAAA);
      mon_on = 1'b0;
      @(negedge tck); rst_n = 1'b0;
      @(negedge tck); rst_n = 1'b1;
      model_clear();
      mon_on = 1'b1;
      bus_read("R12", 32'h0C);

      mon_on = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule